// File: doc/BRIEF.md
# Rotated Immediate Constant Encoder

This block decides whether a 32-bit constant can be written as a 12-bit rotated immediate. That immediate holds an 8-bit value and a 4-bit rotate field. The constant it stands for is the 8-bit value, zero-extended to 32 bits and rotated right by twice the rotate field. An instruction emitter or a constant-materialisation unit can use it to choose between a single-instruction immediate form and a longer fallback.

The encoder works iteratively. A start pulse captures the constant, and the block then tries one rotate candidate per clock, from 0 upward. It stops at the first candidate that matches, or after the last one. At the end it raises a done flag. A valid flag says whether an encoding was found, and the rotate field and 8-bit value are reported beside it. These results stay in place until the next accepted start. A separate, purely combinational port turns any 12-bit immediate field back into its 32-bit value.

Top module: `rimm_enc_top`

## Requirements
- R1: The expand port returns the low 8 bits of the field (bits 7:0), zero-extended to 32 bits and rotated right by twice the rotate field (bits 11:8), for example field 0xC01 gives 0x00000100 and field 0x1FF gives 0xC000003F.
- R2: For an encodable constant the search ends with done=1 and valid=1, and the reported {rot, imm} pair expands to exactly the captured constant, for example 0x000FF000 gives rot 0xA and imm 0xFF.
- R3: When several rotate values reproduce the constant, the smallest one is reported, for example 0x00000010 gives rot 0 and imm 0x10, and 0x40000000 gives rot 1 and imm 0x01.
- R4: For a constant that cannot be encoded (for example 0x000FF800, 0x00000415 or 0x00000102) the search ends with done=1, valid=0, rot=0 and imm=0.
- R5: A match at rotate value r raises done on the (r+1)-th rising edge after the edge that accepts start. A constant that cannot be encoded raises done on the 16th edge.
- R6: After done rises, done, valid, rot and imm hold steady until the next accepted start. An accepted start clears done on the edge that accepts it.
- R7: A start that arrives while a search is in progress is ignored: the running search finishes with its original constant and timing.
- R8: Reset clears done, valid, rot and imm at once. The block reacts to start only after reset has been released and has passed through its two-stage synchronizer.
- R9: valid is never 1 while done is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| start_i | input | 1 | Pulse that captures const_i and begins a search when the block is idle |
| const_i | input | 32 | Constant to encode, sampled together with start_i |
| done_o | output | 1 | The search has finished and the results are valid to read |
| valid_o | output | 1 | The constant fits the rotated immediate format |
| rot_o | output | 4 | Rotate field of the encoding found |
| imm_o | output | 8 | 8-bit value of the encoding found |
| xp_field_i | input | 12 | Immediate field to expand: rotate field in bits 11:8, value in bits 7:0 |
| xp_value_o | output | 32 | 32-bit value that xp_field_i stands for |

## Verification
The assertions assume that start_i and const_i are clean, synchronous inputs. They also assume that no start is given while reset is asserted or while the synchronizer is still releasing it. The checker tracks accepted starts on its own, so it relies on start being the only way a search begins. The bench meets these assumptions: it drives every input on the falling clock edge and waits several cycles after reset before the first start. It raises an overlapping start only while a search is known to be running, which is where the block's ignore behaviour is under test.

// File: rtl/rimm_pkg.sv
package rimm_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned VAL_W  = 8;
  localparam int unsigned ROT_W  = 4;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_state_e;
endpackage

// File: rtl/rimm_candidate.sv
// Tests one rotate candidate: the constant fits at rotate r when rotating
// it left by 2*r leaves nothing above the low VAL_W bits.
module rimm_candidate #(
  parameter int unsigned DATA_W = rimm_pkg::DATA_W,
  parameter int unsigned VAL_W  = rimm_pkg::VAL_W,
  parameter int unsigned ROT_W  = rimm_pkg::ROT_W
) (
  input  logic [DATA_W-1:0] value_i,
  input  logic [ROT_W-1:0]  rot_i,
  output logic              hit_o,
  output logic [VAL_W-1:0]  val_o
);
  localparam int unsigned SH_W = ROT_W + 1;

  logic [SH_W-1:0]     shamt;
  logic [2*DATA_W-1:0] doubled;
  logic [DATA_W-1:0]   rolled;

  always_comb begin
    shamt   = {rot_i, 1'b0};
    doubled = {value_i, value_i} << shamt;
    rolled  = doubled[2*DATA_W-1:DATA_W];
    hit_o   = (rolled[DATA_W-1:VAL_W] == '0);
    val_o   = rolled[VAL_W-1:0];
  end
endmodule

// File: rtl/rimm_expand.sv
// Turns a rotated immediate field back into its full-width value.
module rimm_expand #(
  parameter int unsigned DATA_W = rimm_pkg::DATA_W,
  parameter int unsigned VAL_W  = rimm_pkg::VAL_W,
  parameter int unsigned ROT_W  = rimm_pkg::ROT_W
) (
  input  logic [ROT_W+VAL_W-1:0] field_i,
  output logic [DATA_W-1:0]      value_o
);
  localparam int unsigned SH_W = ROT_W + 1;

  logic [SH_W-1:0]     shamt;
  logic [DATA_W-1:0]   widened;
  logic [2*DATA_W-1:0] doubled;

  always_comb begin
    shamt   = {field_i[ROT_W+VAL_W-1:VAL_W], 1'b0};
    widened = {{(DATA_W-VAL_W){1'b0}}, field_i[VAL_W-1:0]};
    doubled = {widened, widened} >> shamt;
    value_o = doubled[DATA_W-1:0];
  end
endmodule

// File: rtl/rimm_search_ctl.sv
// Search sequencer: captures the constant, walks the rotate candidates from
// the lowest upward and holds the result until the next accepted start.
module rimm_search_ctl #(
  parameter int unsigned DATA_W = rimm_pkg::DATA_W,
  parameter int unsigned VAL_W  = rimm_pkg::VAL_W,
  parameter int unsigned ROT_W  = rimm_pkg::ROT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] const_i,
  input  logic              cand_hit_i,
  input  logic [VAL_W-1:0]  cand_val_i,
  output logic [DATA_W-1:0] cand_value_o,
  output logic [ROT_W-1:0]  cand_rot_o,
  output logic              done_o,
  output logic              valid_o,
  output logic [ROT_W-1:0]  rot_o,
  output logic [VAL_W-1:0]  imm_o
);
  import rimm_pkg::*;

  localparam logic [ROT_W-1:0] LAST_ROT = {ROT_W{1'b1}};

  scan_state_e       state_q, state_d;
  logic [ROT_W-1:0]  step_q, step_d;
  logic [DATA_W-1:0] const_q;
  logic              done_q, done_d;
  logic              valid_q, valid_d;
  logic [ROT_W-1:0]  rot_q, rot_d;
  logic [VAL_W-1:0]  imm_q, imm_d;
  logic              accept;
  logic              res_en;

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    done_d  = done_q;
    valid_d = valid_q;
    rot_d   = rot_q;
    imm_d   = imm_q;
    accept  = 1'b0;
    res_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          accept  = 1'b1;
          res_en  = 1'b1;
          state_d = ST_SCAN;
          step_d  = '0;
          done_d  = 1'b0;
          valid_d = 1'b0;
          rot_d   = '0;
          imm_d   = '0;
        end
      end
      ST_SCAN: begin
        if (cand_hit_i) begin
          res_en  = 1'b1;
          state_d = ST_IDLE;
          done_d  = 1'b1;
          valid_d = 1'b1;
          rot_d   = step_q;
          imm_d   = cand_val_i;
        end else if (step_q == LAST_ROT) begin
          res_en  = 1'b1;
          state_d = ST_IDLE;
          done_d  = 1'b1;
          valid_d = 1'b0;
          rot_d   = '0;
          imm_d   = '0;
        end else begin
          step_d = step_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      const_q <= '0;
    end else if (accept) begin
      const_q <= const_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      valid_q <= 1'b0;
      rot_q   <= '0;
      imm_q   <= '0;
    end else if (res_en) begin
      done_q  <= done_d;
      valid_q <= valid_d;
      rot_q   <= rot_d;
      imm_q   <= imm_d;
    end
  end

  assign cand_value_o = const_q;
  assign cand_rot_o   = step_q;
  assign done_o       = done_q;
  assign valid_o      = valid_q;
  assign rot_o        = rot_q;
  assign imm_o        = imm_q;
endmodule

// File: rtl/rimm_enc_top.sv
module rimm_enc_top #(
  parameter int unsigned DATA_W     = rimm_pkg::DATA_W,
  parameter int unsigned VAL_W      = rimm_pkg::VAL_W,
  parameter int unsigned ROT_W      = rimm_pkg::ROT_W,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [DATA_W-1:0]      const_i,
  output logic                   done_o,
  output logic                   valid_o,
  output logic [ROT_W-1:0]       rot_o,
  output logic [VAL_W-1:0]       imm_o,
  input  logic [ROT_W+VAL_W-1:0] xp_field_i,
  output logic [DATA_W-1:0]      xp_value_o
);
  logic [RST_STAGES-1:0] rst_sync_q;
  logic                  rst_core_n;
  logic [DATA_W-1:0]     cand_value;
  logic [ROT_W-1:0]      cand_rot;
  logic                  cand_hit;
  logic [VAL_W-1:0]      cand_val;

  // Assert asynchronously, release after RST_STAGES clean edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[RST_STAGES-2:0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[RST_STAGES-1];

  rimm_search_ctl #(.DATA_W(DATA_W), .VAL_W(VAL_W), .ROT_W(ROT_W)) u_ctl (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .start_i      (start_i),
    .const_i      (const_i),
    .cand_hit_i   (cand_hit),
    .cand_val_i   (cand_val),
    .cand_value_o (cand_value),
    .cand_rot_o   (cand_rot),
    .done_o       (done_o),
    .valid_o      (valid_o),
    .rot_o        (rot_o),
    .imm_o        (imm_o)
  );

  rimm_candidate #(.DATA_W(DATA_W), .VAL_W(VAL_W), .ROT_W(ROT_W)) u_cand (
    .value_i (cand_value),
    .rot_i   (cand_rot),
    .hit_o   (cand_hit),
    .val_o   (cand_val)
  );

  rimm_expand #(.DATA_W(DATA_W), .VAL_W(VAL_W), .ROT_W(ROT_W)) u_expand (
    .field_i (xp_field_i),
    .value_o (xp_value_o)
  );
endmodule

// File: rtl/rimm_chk.sv
module rimm_chk #(
  parameter int unsigned DATA_W = rimm_pkg::DATA_W,
  parameter int unsigned VAL_W  = rimm_pkg::VAL_W,
  parameter int unsigned ROT_W  = rimm_pkg::ROT_W
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start_i,
  input logic [DATA_W-1:0]      const_i,
  input logic                   done_o,
  input logic                   valid_o,
  input logic [ROT_W-1:0]       rot_o,
  input logic [VAL_W-1:0]       imm_o,
  input logic [ROT_W+VAL_W-1:0] xp_field_i,
  input logic [DATA_W-1:0]      xp_value_o
);
  localparam int unsigned NUM_ROT = 1 << ROT_W;

  logic              pend_q;
  logic [ROT_W+1:0]  wait_q;
  logic [DATA_W-1:0] const_l;

  function automatic logic [DATA_W-1:0] ror_val(input logic [VAL_W-1:0] v,
                                                input logic [ROT_W-1:0] r);
    logic [DATA_W-1:0] w;
    w = {{(DATA_W-VAL_W){1'b0}}, v};
    for (int i = 0; i < 2 * int'(r); i++) w = {w[0], w[DATA_W-1:1]};
    return w;
  endfunction

  // Independent record of accepted searches.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      wait_q  <= '0;
      const_l <= '0;
    end else if (start_i && (!pend_q || done_o)) begin
      pend_q  <= 1'b1;
      wait_q  <= '0;
      const_l <= const_i;
    end else if (pend_q && done_o) begin
      pend_q <= 1'b0;
    end else if (pend_q) begin
      wait_q <= wait_q + 1'b1;
    end
  end

  AST_EXPAND_POPCOUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(xp_value_o) == $countones(xp_field_i[VAL_W-1:0])); // R1

  AST_ROUNDTRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && valid_o) |-> (ror_val(imm_o, rot_o) == const_l)); // R2

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !valid_o) |-> (rot_o == '0 && imm_o == '0)); // R4

  AST_SEARCH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (wait_q <= NUM_ROT)); // R5

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> $stable({done_o, valid_o, rot_o, imm_o})); // R6

  AST_VALID_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> done_o); // R9
endmodule

bind rimm_enc_top rimm_chk #(.DATA_W(DATA_W), .VAL_W(VAL_W), .ROT_W(ROT_W)) u_chk (.*);

// File: tb/tb_rimm_enc_top.sv
module tb_rimm_enc_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;
  localparam int WDOG_LIMIT = 100000;

  // {constant, expected valid, expected 12-bit field}
  localparam logic [44:0] VEC [NVEC] = '{
    {32'h000FF000, 1'b1, 12'hAFF},
    {32'h000FF800, 1'b0, 12'h000},
    {32'h00000415, 1'b0, 12'h000},
    {32'h00000100, 1'b1, 12'hC01},
    {32'h00000004, 1'b1, 12'h004},
    {32'h00000000, 1'b1, 12'h000},
    {32'h000000FF, 1'b1, 12'h0FF},
    {32'hFF000000, 1'b1, 12'h4FF},
    {32'hF000000F, 1'b1, 12'h2FF},
    {32'h00000010, 1'b1, 12'h010},
    {32'h000003FC, 1'b1, 12'hFFF},
    {32'h40000000, 1'b1, 12'h101},
    {32'h80000001, 1'b1, 12'h106},
    {32'hFFFFFFFF, 1'b0, 12'h000},
    {32'h00000102, 1'b0, 12'h000},
    {32'hC000003F, 1'b1, 12'h1FF}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] const_i = '0;
  logic        done_o, valid_o;
  logic [3:0]  rot_o;
  logic [7:0]  imm_o;
  logic [11:0] xp_field_i = '0;
  logic [31:0] xp_value_o;

  int n_checks = 0;
  int n_fails = 0;
  int cycles = 0;
  bit finished = 1'b0;

  rimm_enc_top dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG_LIMIT) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WDOG_LIMIT);
      finish_up();
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Starts a search at a falling edge and returns how many rising edges
  // after the accepting edge done took. Optionally injects a second start
  // with another constant at falling edge number inj_at of the search.
  task automatic run_search(input logic [31:0] c, input int inj_at,
                            input logic [31:0] inj_c, output int lat);
    @(negedge clk);
    const_i = c;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R6 done cleared by start", {31'b0, done_o}, 32'd0);
    lat = 0;
    while (!done_o && lat < 40) begin
      if (lat == inj_at) begin
        const_i = inj_c;
        start_i = 1'b1;
      end
      @(negedge clk);
      start_i = 1'b0;
      lat++;
    end
  endtask

  initial begin
    int lat;
    logic [24:0] snap;
    repeat (3) @(negedge clk);
    check("R8 reset done", {31'b0, done_o}, 32'd0);
    check("R8 reset valid", {31'b0, valid_o}, 32'd0);
    check("R8 reset field", {20'b0, rot_o, imm_o}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: direct expand-port checks
    xp_field_i = 12'hC01; #1 check("R1 expand C01", xp_value_o, 32'h00000100);
    xp_field_i = 12'h1FF; #1 check("R1 expand 1FF", xp_value_o, 32'hC000003F);
    xp_field_i = 12'hF80; #1 check("R1 expand F80", xp_value_o, 32'h00000200);
    xp_field_i = 12'hAFF; #1 check("R1 expand AFF", xp_value_o, 32'h000FF000);

    // Table walk: R2, R3, R4, R5
    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] c;
      logic        ev;
      logic [11:0] ef;
      int          elat;
      {c, ev, ef} = VEC[i];
      elat = ev ? int'(ef[11:8]) + 1 : 16;
      run_search(c, -1, '0, lat);
      check("R5 latency", lat, elat);
      check("R2/R4 valid", {31'b0, valid_o}, {31'b0, ev});
      check("R3/R4 rot and imm", {20'b0, rot_o, imm_o}, {20'b0, ef});
      check("R9 done with result", {31'b0, done_o}, 32'd1);
      if (ev) begin
        xp_field_i = {rot_o, imm_o};
        #1 check("R2 round trip", xp_value_o, c);
      end
    end

    // R6: results held while inputs change with no start
    run_search(32'h00000100, -1, '0, lat);
    snap = {done_o, valid_o, rot_o, imm_o, 11'b0};
    const_i = 32'hDEADBEEF;
    repeat (5) @(negedge clk);
    check("R6 held result", {7'b0, done_o, valid_o, rot_o, imm_o, 11'b0}, {7'b0, snap});

    // R7: start during a running search is ignored
    run_search(32'h000003FC, 3, 32'h00000004, lat);
    check("R7 ignored start latency", lat, 16);
    check("R7 ignored start field", {20'b0, rot_o, imm_o}, 32'h00000FFF);
    check("R7 ignored start valid", {31'b0, valid_o}, 32'd1);

    // R8: reset in the middle of a held result
    run_search(32'h000000FF, -1, '0, lat);
    rst_n = 1'b0;
    #1;
    check("R8 async clear done", {31'b0, done_o}, 32'd0);
    check("R8 async clear valid", {31'b0, valid_o}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_search(32'h00000004, -1, '0, lat);
    check("R8 works after reset", {20'b0, rot_o, imm_o}, 32'h00000004);

    finish_up();
  end
endmodule